// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Invalidation

This block is the translation cache of an I/O memory management unit. It holds recent translations, each tagged by a 16-bit address space identifier (ASID) and a 64-bit input virtual address (IOVA). Each entry stores the output address, an address mask and two permission bits. A page table walker loads entries through the fill port. Requesters probe the cache through the lookup port and get a registered answer one cycle later.

The array is set-associative: 16 sets of 4 ways by default. The set is picked by a Jenkins-style three-word hash of the key. Victims are chosen per set in round-robin order. A command port removes entries in one of three ways: every entry, every entry of one ASID, or one exact {ASID, IOVA} key. Removing by ASID visits one set per clock. While that sweep runs, the block shows busy and holds off all traffic.

Top module: `iotlb_cache`

## Requirements
- R1: A lookup accepted in cycle N answers in cycle N+1 with `rsp_valid`=1. `rsp_hit` is 1 only if a valid entry has both the same ASID and the identical 64-bit IOVA. On a hit, `rsp_oa`, `rsp_mask` and `rsp_perm` carry the stored values. On a miss they are zero. Without an accepted lookup, `rsp_valid` and `rsp_hit` are 0.
- R2: The set of a key is the low log2(SETS) bits of a hash. The hash starts words a, b and c at 0xDEADBEFF. It adds the ASID to a, IOVA[31:0] to b and IOVA[63:32] to c. It then applies the lookup3 mix (rotations 4, 6, 8, 16, 19, 4) and the lookup3 final (rotations 14, 11, 25, 16, 4, 14, 24). The hash value is c. Only keys in the same set compete for ways.
- R3: A fill of a key that is not present writes the way named by that set's round-robin pointer. The pointer then advances by one, modulo WAYS. So the fifth new key filled into one set evicts the first.
- R4: A fill of a key that is already present rewrites that entry in place. It leaves the set's pointer unchanged, so there is never a second copy of the key.
- R5: Command op 1 (remove all) clears every entry in the cycle it is accepted.
- R6: Command op 2 (remove by ASID) holds `busy` high for exactly SETS cycles after acceptance. By the end it has removed every entry with that ASID, and entries of other ASIDs are kept.
- R7: Command op 3 removes only the entry whose ASID and IOVA both equal the command's. Op 0 has no effect.
- R8: While `busy` is high, `lk_ready`, `fill_ready` and `cmd_ready` are 0. A lookup, fill or command offered then is not taken and produces no response.
- R9: When a command is offered, `fill_ready` is 0 and an offered fill is dropped. The command wins the cycle.
- R10: Reset empties the cache, zeroes every round-robin pointer and clears `busy` and `rsp_valid`.
- R11: A lookup sees the contents from before any fill or command accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted this cycle when high |
| lk_asid | input | 16 | Lookup ASID |
| lk_iova | input | 64 | Lookup IOVA |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Lookup found its key |
| rsp_oa | output | 64 | Translated output address |
| rsp_mask | output | 64 | Stored address mask |
| rsp_perm | output | 2 | Stored permission bits |
| fill_valid | input | 1 | Fill request from the walker |
| fill_ready | output | 1 | Fill accepted this cycle when high |
| fill_asid | input | 16 | Fill ASID |
| fill_iova | input | 64 | Fill IOVA |
| fill_oa | input | 64 | Fill output address |
| fill_mask | input | 64 | Fill address mask |
| fill_perm | input | 2 | Fill permission bits |
| cmd_valid | input | 1 | Invalidation command request |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| cmd_op | input | 2 | 0 none, 1 all, 2 by ASID, 3 single key |
| cmd_asid | input | 16 | Command ASID |
| cmd_iova | input | 64 | Command IOVA (op 3 only) |
| busy | output | 1 | ASID sweep in progress |

## Verification
The hardest situation to reach is several distinct keys in one set. It must happen so that round-robin eviction and in-place overwrite can be seen at all. Random keys rarely collide in a way that can be observed. So the bench runs the hash itself and searches IOVAs under one ASID until it has six that land in the same set. It fills five of them and overwrites one. It then adds the sixth and checks which key has been pushed out. The ASID sweep is also exercised with traffic offered on all three ports during the busy window. This confirms that nothing slips into a set the sweep has already visited.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int ASID_W = 16;
    parameter int VA_W   = 64;
    parameter int PA_W   = 64;
    parameter int PERM_W = 2;
    parameter int HASH_W = 32;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_ALL  = 2'd1,
        OP_ASID = 2'd2,
        OP_ONE  = 2'd3
    } inv_op_e;

    typedef struct packed {
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   iova;
        logic [PA_W-1:0]   oa;
        logic [VA_W-1:0]   mask;
        logic [PERM_W-1:0] perm;
    } tlb_ent_t;

endpackage

// File: rtl/tlb_key_hash.sv
module tlb_key_hash
    import tlb_pkg::*;
#(
    parameter logic [HASH_W-1:0] SEED  = 32'hDEADBEFF,
    parameter int                IDX_W = 4
) (
    input  logic [ASID_W-1:0] asid,
    input  logic [VA_W-1:0]   iova,
    output logic [IDX_W-1:0]  idx
);

    function automatic logic [HASH_W-1:0] rotl(input logic [HASH_W-1:0] v, input int s);
        return (v << s) | (v >> (HASH_W - s));
    endfunction

    // Three-word mix followed by the final avalanche; word c carries the result.
    always_comb begin
        logic [HASH_W-1:0] a, b, c;
        a = SEED + {{(HASH_W-ASID_W){1'b0}}, asid};
        b = SEED + iova[HASH_W-1:0];
        c = SEED + iova[VA_W-1:HASH_W];
        // mix
        a = a - c;  a = a ^ rotl(c, 4);   c = c + b;
        b = b - a;  b = b ^ rotl(a, 6);   a = a + c;
        c = c - b;  c = c ^ rotl(b, 8);   b = b + a;
        a = a - c;  a = a ^ rotl(c, 16);  c = c + b;
        b = b - a;  b = b ^ rotl(a, 19);  a = a + c;
        c = c - b;  c = c ^ rotl(b, 4);   b = b + a;
        // final
        c = c ^ b;  c = c - rotl(b, 14);
        a = a ^ c;  a = a - rotl(c, 11);
        b = b ^ a;  b = b - rotl(a, 25);
        c = c ^ b;  c = c - rotl(b, 16);
        a = a ^ c;  a = a - rotl(c, 4);
        b = b ^ a;  b = b - rotl(a, 14);
        c = c ^ b;  c = c - rotl(b, 24);
        idx = c[IDX_W-1:0];
    end

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0]   way_vld,
    input  logic [ASID_W-1:0] way_asid [WAYS],
    input  logic [VA_W-1:0]   way_iova [WAYS],
    input  logic [ASID_W-1:0] key_asid,
    input  logic [VA_W-1:0]   key_iova,
    output logic [WAYS-1:0]   hit
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w] = way_vld[w] && (way_asid[w] == key_asid) && (way_iova[w] == key_iova);
    end

endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
    import tlb_pkg::*;
#(
    parameter int                SETS      = 16,   // power of two
    parameter int                WAYS      = 4,    // power of two
    parameter logic [HASH_W-1:0] HASH_SEED = 32'hDEADBEFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_iova,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_oa,
    output logic [VA_W-1:0]   rsp_mask,
    output logic [PERM_W-1:0] rsp_perm,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VA_W-1:0]   fill_iova,
    input  logic [PA_W-1:0]   fill_oa,
    input  logic [VA_W-1:0]   fill_mask,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ASID_W-1:0] cmd_asid,
    input  logic [VA_W-1:0]   cmd_iova,
    output logic              busy
);

    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);
    localparam int NPORT = 3;
    localparam int P_LK  = 0;
    localparam int P_FL  = 1;
    localparam int P_CM  = 2;

    typedef struct packed {
        logic              busy;
        logic [SET_W-1:0]  sweep;
        logic [ASID_W-1:0] sw_asid;
        logic              rsp_vld;
        logic              rsp_hit;
        logic [PA_W-1:0]   rsp_oa;
        logic [VA_W-1:0]   rsp_mask;
        logic [PERM_W-1:0] rsp_perm;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    tlb_ent_t         ent_d [SETS][WAYS];
    tlb_ent_t         ent_q [SETS][WAYS];
    logic [WAY_W-1:0] rr_d  [SETS];
    logic [WAY_W-1:0] rr_q  [SETS];

    // ---------------- key ports: hash and way compare per port ----------------
    logic [ASID_W-1:0]             q_asid [NPORT];
    logic [VA_W-1:0]               q_iova [NPORT];
    logic [NPORT-1:0][SET_W-1:0]   q_set;
    logic [NPORT-1:0][WAYS-1:0]    q_hit;

    assign q_asid[P_LK] = lk_asid;
    assign q_iova[P_LK] = lk_iova;
    assign q_asid[P_FL] = fill_asid;
    assign q_iova[P_FL] = fill_iova;
    assign q_asid[P_CM] = cmd_asid;
    assign q_iova[P_CM] = cmd_iova;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [WAYS-1:0]   way_vld;
        logic [ASID_W-1:0] way_asid [WAYS];
        logic [VA_W-1:0]   way_iova [WAYS];

        tlb_key_hash #(
            .SEED  (HASH_SEED),
            .IDX_W (SET_W)
        ) u_hash (
            .asid (q_asid[p]),
            .iova (q_iova[p]),
            .idx  (q_set[p])
        );

        always_comb begin
            for (int w = 0; w < WAYS; w++) begin
                way_vld[w]  = ent_q[q_set[p]][w].vld;
                way_asid[w] = ent_q[q_set[p]][w].asid;
                way_iova[w] = ent_q[q_set[p]][w].iova;
            end
        end

        tlb_way_match #(
            .WAYS (WAYS)
        ) u_match (
            .way_vld  (way_vld),
            .way_asid (way_asid),
            .way_iova (way_iova),
            .key_asid (q_asid[p]),
            .key_iova (q_iova[p]),
            .hit      (q_hit[p])
        );
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        logic             lk_acc, fl_acc, cm_acc;
        logic [WAY_W-1:0] fl_way;

        ctl_d  = ctl_q;
        ent_d  = ent_q;
        rr_d   = rr_q;
        fl_way = rr_q[q_set[P_FL]];

        lk_acc = lk_valid   && !ctl_q.busy;
        cm_acc = cmd_valid  && !ctl_q.busy;
        fl_acc = fill_valid && !ctl_q.busy && !cmd_valid;

        // lookup answer reads the array as it stands before this cycle's writes
        ctl_d.rsp_vld  = lk_acc;
        ctl_d.rsp_hit  = 1'b0;
        ctl_d.rsp_oa   = '0;
        ctl_d.rsp_mask = '0;
        ctl_d.rsp_perm = '0;
        if (lk_acc) begin
            for (int w = 0; w < WAYS; w++) begin
                if (q_hit[P_LK][w]) begin
                    ctl_d.rsp_hit  = 1'b1;
                    ctl_d.rsp_oa   = ent_q[q_set[P_LK]][w].oa;
                    ctl_d.rsp_mask = ent_q[q_set[P_LK]][w].mask;
                    ctl_d.rsp_perm = ent_q[q_set[P_LK]][w].perm;
                end
            end
        end

        // ASID sweep: one set per clock
        if (ctl_q.busy) begin
            for (int w = 0; w < WAYS; w++) begin
                if (ent_q[ctl_q.sweep][w].asid == ctl_q.sw_asid) begin
                    ent_d[ctl_q.sweep][w].vld = 1'b0;
                end
            end
            if (ctl_q.sweep == LAST_SET) begin
                ctl_d.busy = 1'b0;
            end else begin
                ctl_d.sweep = ctl_q.sweep + 1'b1;
            end
        end

        // invalidation commands
        if (cm_acc) begin
            case (inv_op_e'(cmd_op))
                OP_ALL: begin
                    for (int s = 0; s < SETS; s++) begin
                        for (int w = 0; w < WAYS; w++) begin
                            ent_d[s][w].vld = 1'b0;
                        end
                    end
                end
                OP_ASID: begin
                    ctl_d.busy    = 1'b1;
                    ctl_d.sweep   = '0;
                    ctl_d.sw_asid = cmd_asid;
                end
                OP_ONE: begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (q_hit[P_CM][w]) begin
                            ent_d[q_set[P_CM]][w].vld = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end

        // fill: overwrite a present key in place, else take the round-robin way
        if (fl_acc) begin
            if (|q_hit[P_FL]) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (q_hit[P_FL][w]) begin
                        fl_way = WAY_W'(w);
                    end
                end
            end else begin
                rr_d[q_set[P_FL]] = rr_q[q_set[P_FL]] + 1'b1;
            end
            ent_d[q_set[P_FL]][fl_way] = '{
                vld:  1'b1,
                asid: fill_asid,
                iova: fill_iova,
                oa:   fill_oa,
                mask: fill_mask,
                perm: fill_perm
            };
        end
    end

    // ---------------- state registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    ent_q[s][w] <= '0;
                end
            end
        end else begin
            ctl_q <= ctl_d;
            ent_q <= ent_d;
            rr_q  <= rr_d;
        end
    end

    assign lk_ready   = !ctl_q.busy;
    assign cmd_ready  = !ctl_q.busy;
    assign fill_ready = !ctl_q.busy && !cmd_valid;
    assign busy       = ctl_q.busy;
    assign rsp_valid  = ctl_q.rsp_vld;
    assign rsp_hit    = ctl_q.rsp_hit;
    assign rsp_oa     = ctl_q.rsp_oa;
    assign rsp_mask   = ctl_q.rsp_mask;
    assign rsp_perm   = ctl_q.rsp_perm;

    // ---------------- assertions ----------------
    logic [SETS*WAYS-1:0] vld_flat;
    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                vld_flat[s*WAYS + w] = ent_q[s][w].vld;
            end
        end
    end

    logic [SET_W:0] chk_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_age <= '0;
        end else begin
            chk_age <= busy ? chk_age + 1'b1 : '0;
        end
    end

    a_r1_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> (!rsp_valid && !rsp_hit));

    a_r4_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_hit[P_LK]) && $onehot0(q_hit[P_FL]) && $onehot0(q_hit[P_CM]));

    a_r5_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_ALL) |=> (vld_flat == '0));

    a_r6_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && cmd_ready && cmd_op == OP_ASID));

    a_r6_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (chk_age < (SET_W+1)'(SETS)));

    a_r8_no_answer_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && busy) |=> !rsp_valid);

endmodule

// File: tb/iotlb_cache_bench.sv
module iotlb_cache_bench;

    localparam int SETS = 16;
    localparam int WAYS = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        lk_valid, lk_ready;
    logic [15:0] lk_asid;
    logic [63:0] lk_iova;
    logic        rsp_valid, rsp_hit;
    logic [63:0] rsp_oa, rsp_mask;
    logic [1:0]  rsp_perm;
    logic        fill_valid, fill_ready;
    logic [15:0] fill_asid;
    logic [63:0] fill_iova, fill_oa, fill_mask;
    logic [1:0]  fill_perm;
    logic        cmd_valid, cmd_ready;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_asid;
    logic [63:0] cmd_iova;
    logic        busy;

    iotlb_cache u_iotlb_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_asid(lk_asid), .lk_iova(lk_iova),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_oa(rsp_oa), .rsp_mask(rsp_mask),
        .rsp_perm(rsp_perm),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_asid(fill_asid),
        .fill_iova(fill_iova), .fill_oa(fill_oa), .fill_mask(fill_mask), .fill_perm(fill_perm),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_asid(cmd_asid),
        .cmd_iova(cmd_iova), .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference
    bit          m_vld  [SETS][WAYS];
    logic [15:0] m_asid [SETS][WAYS];
    logic [63:0] m_iova [SETS][WAYS];
    logic [63:0] m_oa   [SETS][WAYS];
    logic [63:0] m_mask [SETS][WAYS];
    logic [1:0]  m_perm [SETS][WAYS];
    int          m_ptr  [SETS];
    int          m_busy;
    bit          e_rv, e_hit;
    logic [63:0] e_oa, e_mask;
    logic [1:0]  e_perm;
    logic [63:0] col [6];

    function automatic logic [31:0] rl(logic [31:0] x, int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic int bset(logic [15:0] ai, logic [63:0] v);
        logic [31:0] a, b, c;
        a = 32'hDEADBEEF + 32'd16;
        b = a;
        c = a;
        a += {16'h0, ai};
        b += v[31:0];
        c += v[63:32];
        a -= c; a ^= rl(c, 4);  c += b;
        b -= a; b ^= rl(a, 6);  a += c;
        c -= b; c ^= rl(b, 8);  b += a;
        a -= c; a ^= rl(c, 16); c += b;
        b -= a; b ^= rl(a, 19); a += c;
        c -= b; c ^= rl(b, 4);  b += a;
        c ^= b; c -= rl(b, 14);
        a ^= c; a -= rl(c, 11);
        b ^= a; b -= rl(a, 25);
        c ^= b; c -= rl(b, 16);
        a ^= c; a -= rl(c, 4);
        b ^= a; b -= rl(a, 14);
        c ^= b; c -= rl(b, 24);
        return int'(c[3:0]);
    endfunction

    function automatic int m_find(logic [15:0] a, logic [63:0] v);
        int s = bset(a, v);
        for (int w = 0; w < WAYS; w++) begin
            if (m_vld[s][w] && m_asid[s][w] == a && m_iova[s][w] == v) return w;
        end
        return -1;
    endfunction

    task automatic m_clear();
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) m_vld[s][w] = 1'b0;
        end
        m_busy = 0;
    endtask

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one clock: inputs are already driven; called at a falling edge
    task automatic step();
        bit la, fa, ca;
        int s, w;
        la = lk_valid && m_busy == 0;
        ca = cmd_valid && m_busy == 0;
        fa = fill_valid && m_busy == 0 && !cmd_valid;
        #1;
        chk("R8", "lk_ready", lk_ready, m_busy == 0);
        chk("R8", "cmd_ready", cmd_ready, m_busy == 0);
        chk("R9", "fill_ready", fill_ready, m_busy == 0 && !cmd_valid);
        e_rv = la; e_hit = 1'b0; e_oa = '0; e_mask = '0; e_perm = '0;
        if (la) begin
            w = m_find(lk_asid, lk_iova);
            if (w >= 0) begin
                s = bset(lk_asid, lk_iova);
                e_hit = 1'b1; e_oa = m_oa[s][w]; e_mask = m_mask[s][w]; e_perm = m_perm[s][w];
            end
        end
        if (m_busy > 0) m_busy--;
        if (ca) begin
            case (cmd_op)
                2'd1: for (int i = 0; i < SETS; i++) for (int j = 0; j < WAYS; j++) m_vld[i][j] = 1'b0;
                2'd2: begin
                    for (int i = 0; i < SETS; i++)
                        for (int j = 0; j < WAYS; j++)
                            if (m_asid[i][j] == cmd_asid) m_vld[i][j] = 1'b0;
                    m_busy = SETS;
                end
                2'd3: begin
                    w = m_find(cmd_asid, cmd_iova);
                    if (w >= 0) m_vld[bset(cmd_asid, cmd_iova)][w] = 1'b0;
                end
                default: ;
            endcase
        end
        if (fa) begin
            s = bset(fill_asid, fill_iova);
            w = m_find(fill_asid, fill_iova);
            if (w < 0) begin
                w = m_ptr[s];
                m_ptr[s] = (m_ptr[s] + 1) % WAYS;
            end
            m_vld[s][w] = 1'b1; m_asid[s][w] = fill_asid; m_iova[s][w] = fill_iova;
            m_oa[s][w] = fill_oa; m_mask[s][w] = fill_mask; m_perm[s][w] = fill_perm;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R1", "rsp_valid", rsp_valid, e_rv);
        chk("R1", "rsp_hit", rsp_hit, e_hit);
        if (e_rv) begin
            chk("R1", "rsp_oa", rsp_oa, e_oa);
            chk("R1", "rsp_mask", rsp_mask, e_mask);
            chk("R1", "rsp_perm", rsp_perm, e_perm);
        end
        chk("R6", "busy", busy, m_busy != 0);
    endtask

    task automatic idle();
        lk_valid = 0; fill_valid = 0; cmd_valid = 0;
    endtask

    task automatic do_look(logic [15:0] a, logic [63:0] v);
        idle(); lk_valid = 1; lk_asid = a; lk_iova = v;
        step(); idle();
    endtask

    task automatic do_fill(logic [15:0] a, logic [63:0] v, logic [63:0] oa, logic [1:0] pm);
        idle(); fill_valid = 1; fill_asid = a; fill_iova = v;
        fill_oa = oa; fill_mask = 64'hFFF; fill_perm = pm;
        step(); idle();
    endtask

    task automatic do_cmd(logic [1:0] op, logic [15:0] a, logic [63:0] v);
        idle(); cmd_valid = 1; cmd_op = op; cmd_asid = a; cmd_iova = v;
        step(); idle();
    endtask

    localparam logic [63:0] VA = 64'h0000_0040_0001_3000;
    localparam logic [63:0] VH = 64'hFFFF_FFFF_8000_0000;

    initial begin
        int tgt, k, n, far;
        logic [63:0] v;
        rst_n = 0;
        idle();
        lk_asid = 0; lk_iova = 0; fill_asid = 0; fill_iova = 0; fill_oa = 0;
        fill_mask = 0; fill_perm = 0; cmd_op = 0; cmd_asid = 0; cmd_iova = 0;
        m_clear();
        repeat (3) @(negedge clk);
        chk("R10", "busy in reset", busy, 0);
        chk("R10", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1;
        @(negedge clk);

        // R10: empty after reset
        do_look(16'd1, VA);
        chk("R10", "miss after reset", rsp_hit, 0);

        // R1: exact key match
        do_fill(16'd1, VA, 64'h0000_0080_0000_2000, 2'd3);
        do_fill(16'd2, VA, 64'h0000_0090_0000_5000, 2'd1);
        do_fill(16'd1, VH, 64'h0000_00A0_1234_0000, 2'd2);
        do_look(16'd1, VA);
        chk("R1", "hit asid1", rsp_hit, 1);
        chk("R1", "oa asid1", rsp_oa, 64'h0000_0080_0000_2000);
        do_look(16'd2, VA);
        chk("R1", "oa asid2", rsp_oa, 64'h0000_0090_0000_5000);
        do_look(16'd3, VA);
        chk("R1", "other asid misses", rsp_hit, 0);
        do_look(16'd1, VA + 64'h1000);
        chk("R1", "other iova misses", rsp_hit, 0);
        do_look(16'd1, VH ^ 64'h8000_0000_0000_0000);
        chk("R1", "top bit differs misses", rsp_hit, 0);
        do_look(16'd1, VH);
        chk("R1", "high iova hits", rsp_hit, 1);

        // R11: same-cycle lookup and fill of one key
        idle();
        lk_valid = 1; lk_asid = 16'd5; lk_iova = 64'h5000;
        fill_valid = 1; fill_asid = 16'd5; fill_iova = 64'h5000;
        fill_oa = 64'h7700_0000; fill_mask = 64'hFFF; fill_perm = 2'd1;
        step(); idle();
        chk("R11", "lookup sees old state", rsp_hit, 0);
        do_look(16'd5, 64'h5000);
        chk("R11", "visible next cycle", rsp_hit, 1);

        // R2/R3/R4: six colliding keys under ASID 7
        col[0] = 64'h1000;
        tgt = bset(16'd7, col[0]);
        k = 1;
        v = 64'h2000;
        while (k < 6) begin
            if (bset(16'd7, v) == tgt) begin col[k] = v; k++; end
            v += 64'h1000;
        end
        far = 0;
        v = 64'h9_0000;
        while (far == 0) begin
            if (bset(16'd7, v) != tgt) far = 1; else v += 64'h1000;
        end
        do_fill(16'd7, v, 64'hF00D_0000, 2'd3);
        for (int i = 0; i < 5; i++) do_fill(16'd7, col[i], 64'h1_0000 * (i + 1), 2'd2);
        do_look(16'd7, col[0]);
        chk("R3", "first of five evicted", rsp_hit, 0);
        do_look(16'd7, col[1]);
        chk("R3", "second still held", rsp_hit, 1);
        do_look(16'd7, v);
        chk("R2", "other set untouched", rsp_hit, 1);
        do_fill(16'd7, col[2], 64'hABCD_0000, 2'd1);
        do_look(16'd7, col[2]);
        chk("R4", "overwritten oa", rsp_oa, 64'hABCD_0000);
        chk("R4", "overwritten perm", rsp_perm, 2'd1);
        do_fill(16'd7, col[5], 64'h6_0000, 2'd3);
        do_look(16'd7, col[1]);
        chk("R4", "pointer kept: col1 evicted", rsp_hit, 0);
        do_look(16'd7, col[2]);
        chk("R4", "overwritten entry kept", rsp_hit, 1);

        // R7: single-key removal
        do_cmd(2'd3, 16'd8, col[4]);
        do_look(16'd7, col[4]);
        chk("R7", "wrong asid keeps entry", rsp_hit, 1);
        do_cmd(2'd0, 16'd7, col[4]);
        do_look(16'd7, col[4]);
        chk("R7", "op0 no effect", rsp_hit, 1);
        do_cmd(2'd3, 16'd7, col[3]);
        do_look(16'd7, col[3]);
        chk("R7", "removed key misses", rsp_hit, 0);
        do_look(16'd7, col[4]);
        chk("R7", "neighbour kept", rsp_hit, 1);

        // R6/R8: remove by ASID with traffic during the sweep
        for (int i = 0; i < 6; i++) do_fill(16'd9, 64'h20_0000 + i * 64'h1000, 64'h9900 + i, 2'd3);
        do_cmd(2'd2, 16'd9, 64'h0);
        n = 0;
        while (busy && n < 100) begin
            idle();
            lk_valid = 1; lk_asid = 16'd9; lk_iova = 64'h20_0000;
            fill_valid = (n % 2 == 0); fill_asid = 16'd9; fill_iova = 64'h30_0000;
            cmd_valid = (n == 3); cmd_op = 2'd1;
            step();
            if (n == 0) chk("R8", "no answer while busy", rsp_valid, 0);
            n++;
        end
        idle();
        chk("R6", "busy span", n, SETS);
        do_look(16'd9, 64'h20_0000);
        chk("R6", "asid 9 removed", rsp_hit, 0);
        do_look(16'd9, 64'h30_0000);
        chk("R8", "fill during busy dropped", rsp_hit, 0);
        do_look(16'd1, VA);
        chk("R6", "asid 1 kept", rsp_hit, 1);

        // R9/R5: command and fill together, remove all
        idle();
        cmd_valid = 1; cmd_op = 2'd1; cmd_asid = 0; cmd_iova = 0;
        fill_valid = 1; fill_asid = 16'd4; fill_iova = 64'h4000;
        fill_oa = 64'h1; fill_mask = 64'hFFF; fill_perm = 2'd3;
        step(); idle();
        do_look(16'd4, 64'h4000);
        chk("R9", "fill dropped", rsp_hit, 0);
        do_look(16'd1, VA);
        chk("R5", "all removed", rsp_hit, 0);
        do_look(16'd7, col[2]);
        chk("R5", "all removed set", rsp_hit, 0);

        // mixed random traffic
        for (int c = 0; c < 600; c++) begin
            int pk;
            idle();
            lk_valid = $urandom % 2;
            lk_asid = 16'($urandom % 3) + 16'd6;
            pk = $urandom % 8;
            lk_iova = (pk < 6) ? col[pk] : 64'h7_0000 + 64'(pk);
            fill_valid = ($urandom % 3) == 0;
            fill_asid = 16'($urandom % 3) + 16'd6;
            pk = $urandom % 8;
            fill_iova = (pk < 6) ? col[pk] : 64'h7_0000 + 64'(pk);
            fill_oa = {32'h0, $urandom};
            fill_mask = 64'hFFF;
            fill_perm = 2'($urandom % 4);
            cmd_valid = ($urandom % 12) == 0;
            cmd_op = 2'($urandom % 4);
            cmd_asid = 16'($urandom % 3) + 16'd6;
            pk = $urandom % 8;
            cmd_iova = (pk < 6) ? col[pk] : 64'h7_0000 + 64'(pk);
            step();
        end
        idle();
        while (busy) step();

        // R10: reset in the middle of use
        do_fill(16'd1, VA, 64'h55, 2'd3);
        rst_n = 0;
        #1;
        chk("R10", "busy cleared", busy, 0);
        chk("R10", "rsp cleared", rsp_valid, 0);
        m_clear();
        @(negedge clk);
        rst_n = 1;
        do_look(16'd1, VA);
        chk("R10", "emptied by reset", rsp_hit, 0);
        for (int i = 0; i < 5; i++) do_fill(16'd7, col[i], 64'h1000 + i, 2'd1);
        do_look(16'd7, col[0]);
        chk("R10", "pointer restarted at 0", rsp_hit, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule